// File: doc/BRIEF.md
# Double-Width Unsigned Multiplier from Quarter Products

This block multiplies two unsigned operands of 2N bits each and returns the complete 4N-bit product in the same cycle, with no clock. Each operand is split into an upper and a lower half of N bits. Four N×N sub-multipliers form the products lo·lo, hi·lo, lo·hi and hi·hi. The block then aligns these four products by weight and adds them.

The four products are stacked so that the matrix has the fewest possible rows. The low N bits of lo·lo are final product bits and are passed straight to the output. The upper half of lo·lo and the lower half of hi·hi sit side by side in one 2N-bit row. That row and the two cross products, which carry the same weight, go through a single level of full-adder carry-save compression. A 3N-bit carry-propagate adder then merges the save and carry vectors with the upper half of hi·hi. The final carry out of that adder is always zero and is discarded.

The block fits any datapath that needs a wide product built from narrower multiplier cells. The half width N is a parameter.

Top module: `dw_mul`

## Requirements
- R1: For every pair of 2N-bit unsigned operands, `prod` equals the exact unsigned product `opa * opb`, expressed in 4N bits.
- R2: Bits N-1..0 of `prod` equal bits N-1..0 of the product of the lower halves, `opa[N-1:0] * opb[N-1:0]`.
- R3: For each of the 2N centre columns, the carry-save stage keeps the sum of its three input rows. The save vector plus twice the carry vector equals the sum of the three rows.
- R4: Bits 4N-1..N of `prod` equal the exact product shifted right by N bits. No carry is lost between the centre columns and the top N columns.
- R5: If either operand is zero, `prod` is zero.
- R6: When both operands are all ones, `prod` equals 2^(4N) - 2^(2N+1) + 1. This is the largest product, and it is not truncated.
- R7: When one operand equals one, `prod` equals the other operand, zero-extended to 4N bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa  | input     | 2N    | First unsigned operand |
| opb  | input     | 2N    | Second unsigned operand |
| prod | output    | 4N    | Unsigned product opa·opb |

## Verification
The assertions are combinational and assume that both operands are settled, known unsigned values. They also assume that the product fits in 4N bits, which holds for any 2N-bit inputs, so that discarding the adder's carry out is safe.

The stimulus drives only fully defined values and changes the operands away from the clock edge that samples them. Seeded random pairs are mixed with directed values that stress the carry path: all ones, single set halves, one and zero.

// File: rtl/dw_mul.sv
module dw_qmul #(
  parameter int N = 8
) (
  input  logic [N-1:0]   a,
  input  logic [N-1:0]   b,
  output logic [2*N-1:0] p
);
  assign p = {{N{1'b0}}, a} * {{N{1'b0}}, b};
endmodule

module dw_mul #(
  parameter int N = 8
) (
  input  logic [2*N-1:0] opa,
  input  logic [2*N-1:0] opb,
  output logic [4*N-1:0] prod
);
  localparam int W = 2 * N;
  localparam int P = 4 * N;
  localparam int C = 3 * N;

  logic [W-1:0] ll, hl, lh, hh;
  logic [W-1:0] row0, sv, cv;
  logic [C-1:0] add_a, add_b, add_s;

  dw_qmul #(.N(N)) u_ll (.a(opa[N-1:0]), .b(opb[N-1:0]), .p(ll));
  dw_qmul #(.N(N)) u_hl (.a(opa[W-1:N]), .b(opb[N-1:0]), .p(hl));
  dw_qmul #(.N(N)) u_lh (.a(opa[N-1:0]), .b(opb[W-1:N]), .p(lh));
  dw_qmul #(.N(N)) u_hh (.a(opa[W-1:N]), .b(opb[W-1:N]), .p(hh));

  assign row0 = {hh[N-1:0], ll[W-1:N]};

  for (genvar i = 0; i < W; i++) begin : g_csa
    assign sv[i] = row0[i] ^ hl[i] ^ lh[i];
    assign cv[i] = (row0[i] & hl[i]) | (row0[i] & lh[i]) | (hl[i] & lh[i]);
  end

  assign add_a = {hh[W-1:N], sv};
  assign add_b = {{(N-1){1'b0}}, cv, 1'b0};
  assign add_s = add_a + add_b;

  assign prod = {add_s, ll[N-1:0]};

  logic [P-1:0] chk_full;
  logic [W+1:0] chk_rows, chk_csa;
  assign chk_full = {{W{1'b0}}, opa} * {{W{1'b0}}, opb};
  assign chk_rows = {2'b00, row0} + {2'b00, hl} + {2'b00, lh};
  assign chk_csa  = {2'b00, sv} + {1'b0, cv, 1'b0};

  always_comb begin
    p_exact_r1: assert (prod == chk_full)
      else $error("R1 product mismatch");
    p_low_pass_r2: assert (prod[N-1:0] == W'({{N{1'b0}}, opa[N-1:0]} * {{N{1'b0}}, opb[N-1:0]}) % (W'(1) << N))
      else $error("R2 low bits");
    p_csa_sum_r3: assert (chk_csa == chk_rows)
      else $error("R3 carry-save sum");
    p_no_lost_carry_r4: assert (prod[P-1:N] == chk_full[P-1:N])
      else $error("R4 upper bits");
    p_zero_r5: assert (!(opa == '0 || opb == '0) || prod == '0)
      else $error("R5 zero operand");
    p_unit_r7: assert (!(opa == W'(1)) || prod == {{W{1'b0}}, opb})
      else $error("R7 unit operand");
  end
endmodule

// File: tb/tb_dw_mul.sv
module tb_dw_mul;
  localparam int N = 8;
  localparam int W = 2 * N;
  localparam int P = 4 * N;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [W-1:0] opa = '0, opb = '0;
  logic [P-1:0] prod;
  int total = 0, bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  dw_mul #(.N(N)) dut (.opa(opa), .opb(opb), .prod(prod));

  function automatic logic [P-1:0] ref_mul(logic [W-1:0] a, logic [W-1:0] b);
    logic [63:0] acc = 64'd0;
    for (int i = 0; i < W; i++)
      if (b[i]) acc = acc + (64'(a) << i);
    return acc[P-1:0];
  endfunction

  task automatic chk(string req, logic [P-1:0] act, logic [P-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s opa=%h opb=%h act=%h exp=%h", req, opa, opb, act, exp);
    end
  endtask

  task automatic apply(logic [W-1:0] a, logic [W-1:0] b, string req);
    logic [P-1:0] e;
    @(negedge clk);
    opa = a; opb = b;
    #1;
    e = ref_mul(a, b);
    chk(req, prod, e);
    chk("R2", {{(P-N){1'b0}}, prod[N-1:0]}, {{(P-N){1'b0}}, e[N-1:0]});
    chk("R4", {{N{1'b0}}, prod[P-1:N]}, {{N{1'b0}}, e[P-1:N]});
  endtask

  initial begin
    logic [P-1:0] allone;
    void'($urandom(32'd4242));
    repeat (2) @(posedge clk);
    rst = 1'b0;
    #1 chk("R5 idle", prod, '0);
    apply('0, '0, "R5");
    apply('1, '0, "R5");
    apply(16'h1234, '0, "R5");
    allone = (P'(1) << P) - (P'(1) << (W + 1)) + P'(1);
    @(negedge clk); opa = '1; opb = '1; #1;
    chk("R6", prod, allone);
    apply('1, '1, "R6 R1");
    apply(W'(1), 16'hbeef, "R7");
    apply(16'hbeef, W'(1), "R7");
    apply(W'(1), '1, "R7");
    apply({N{1'b1}}, '1, "R3 R1");
    apply({{N{1'b1}}, {N{1'b0}}}, '1, "R3 R4");
    apply({{N{1'b1}}, {N{1'b0}}}, {{N{1'b1}}, {N{1'b0}}}, "R1");
    apply({N{1'b1}}, {N{1'b1}}, "R2");
    for (int k = 0; k < 3000; k++) begin
      logic [W-1:0] a, b;
      a = W'($urandom);
      b = W'($urandom);
      if (k % 7 == 0) a = a | {1'b1, {(W-1){1'b0}}};
      if (k % 11 == 0) b = '1;
      apply(a, b, "R1 R3");
    end
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule